// File: doc/BRIEF.md
# CPU Interrupt Acceptance Controller

This block decides when an 8-bit CPU stops its instruction stream to service an interrupt. It holds the two interrupt-enable flip-flops (`en_main` gates acceptance, `en_save` keeps a saved copy), the 2-bit interrupt mode and the 8-bit vector-page register. The instruction decoder reports every opcode byte it executes. Each byte comes with a page bit that separates the main page from the extended (prefix-ED) page. The decoder also pulses `bnd` when a whole instruction has finished. The block watches the non-maskable line for a falling edge and samples the level-sensitive maskable line at those boundaries.

When it accepts an interrupt, the block updates its flip-flops and issues one action record on a valid/ready port. The record gives the kind of action, a 16-bit target or table address, the bus byte captured for the maskable case, the accept cycle count, and a flag that tells the sequencer to step the PC past a HALT. While a record is pending (`act_valid` high and `act_ready` low), the record holds stable. No new decision is made until the sequencer takes it. Pushing the PC and fetching memory belong to the sequencer.

An opcode and the boundary that ends its instruction may arrive in the same cycle. In that case the opcode's effect counts before the decision at that boundary.

Top module: `irqc_top`

## Requirements
- R1: While reset is active and after it is released, both enable flip-flops, the mode and the vector page read 0, `halt_o` is low and `act_valid` is low.
- R2: Main-page F3h clears both enable flip-flops. Main-page FBh sets both.
- R3: Any extended-page byte matching 01xxx101b copies `en_save` into `en_main` and leaves `en_save` unchanged.
- R4: An extended-page byte 01xxx110b sets the mode from bits 4:3: 00 or 01 selects mode 0, 10 selects mode 1, 11 selects mode 2. Extended-page 47h loads the vector page from `acc_in`.
- R5: A falling edge on `nmi_n` stays latched until it is serviced. It is accepted at the next eligible boundary whatever `en_main` holds. Its record is kind 0 with address 0066h and 11 cycles. It clears `en_main` only.
- R6: A low `int_n` at an eligible boundary is accepted only when `en_main` is 1, and it then clears both flip-flops. When `en_main` is 0 the line is ignored and no record appears.
- R7: When a latched NMI and a low `int_n` meet at the same boundary, the NMI is taken.
- R8: Maskable records depend on the mode. Mode 0 gives kind 2 with address 0000h and 13 cycles. Mode 1 gives kind 1 with address 0038h and 13 cycles. Mode 2 gives kind 3 with address {vector page, bus byte} and 19 cycles. In each case `act_byte` carries `int_bus`.
- R9: No interrupt, NMI included, is accepted at the boundary that ends an instruction containing F3h, FBh, DDh or FDh (main page). The boundary after that one is eligible again.
- R10: Main-page 76h raises `halt_o`, which stays high until an interrupt is accepted. That record has `act_halt_exit` = 1.
- R11: Extended-page 57h or 5Fh pulses `pv_valid` in the next cycle, with `pv_o` equal to `en_save` as it stood when the byte arrived.
- R12: A record holds all its fields while `act_valid` is high and `act_ready` is low. No acceptance takes place while a record is pending, and a new NMI edge stays latched meanwhile.
- R13: Acceptance happens only in a cycle where `bnd` is high. A record appears in the cycle after that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| int_n | input | 1 | Maskable request, active low, level sensitive |
| int_bus | input | 8 | Byte placed on the data bus by the interrupting device |
| op_valid | input | 1 | Decoder presents an executed opcode byte |
| op_ext | input | 1 | 1 = extended page, 0 = main page |
| op_byte | input | 8 | Opcode byte |
| acc_in | input | 8 | Accumulator value for the vector-page load |
| bnd | input | 1 | Instruction boundary strobe |
| act_valid | output | 1 | Action record pending |
| act_ready | input | 1 | Sequencer takes the record |
| act_kind | output | 2 | 0 NMI, 1 restart 38h, 2 bus instruction, 3 vector table |
| act_addr | output | 16 | Target or table address |
| act_byte | output | 8 | Captured bus byte (0 for NMI) |
| act_cycles | output | 5 | Accept cycle count |
| act_halt_exit | output | 1 | PC must step past a HALT |
| halt_o | output | 1 | CPU is halted |
| en_main | output | 1 | Acceptance enable flip-flop |
| en_save | output | 1 | Saved enable flip-flop |
| mode_o | output | 2 | Interrupt mode |
| vpage_o | output | 8 | Vector page register |
| pv_valid | output | 1 | Enable copy for the flag path is valid |
| pv_o | output | 1 | Copy of `en_save` |

## Verification
The in-RTL properties check the following on every cycle:
- records are held stable under back-pressure;
- every acceptance coincides with a non-inhibited boundary;
- an NMI acceptance leaves the saved flip-flop untouched, while a maskable one clears both;
- HALT is released only together with a record flagged for PC advance;
- the latched NMI edge persists until it is consumed.

Other behaviour can only be shown by the bench's scenarios and its reference model:
- the opcode-to-mode mapping;
- the address and cycle count for each mode;
- the one-boundary hold-off after enable, disable and index prefixes;
- the NMI-over-INT priority;
- an edge that arrives while a record is stalled being serviced later.

// File: rtl/icu_pkg.sv
package icu_pkg;

  typedef enum logic [1:0] {
    ACT_NMI = 2'd0,
    ACT_RST = 2'd1,
    ACT_BUS = 2'd2,
    ACT_TBL = 2'd3
  } act_kind_e;

  typedef struct packed {
    logic       dis;
    logic       ena;
    logic       pfx;
    logic       halt;
    logic       retx;
    logic       im_set;
    logic [1:0] im_val;
    logic       ld_pg;
    logic       rd_ir;
  } op_cmd_t;

  // main-page opcodes
  localparam logic [7:0] OPC_DI   = 8'hF3;
  localparam logic [7:0] OPC_EI   = 8'hFB;
  localparam logic [7:0] OPC_IXP  = 8'hDD;
  localparam logic [7:0] OPC_IYP  = 8'hFD;
  localparam logic [7:0] OPC_HALT = 8'h76;
  // extended-page opcodes
  localparam logic [7:0] EXT_LDI  = 8'h47;
  localparam logic [7:0] EXT_RDI  = 8'h57;
  localparam logic [7:0] EXT_RDR  = 8'h5F;

endpackage

// File: rtl/icu_decode.sv
module icu_decode
  import icu_pkg::*;
(
  input  logic       op_valid,
  input  logic       op_ext,
  input  logic [7:0] op_byte,
  output op_cmd_t    cmd
);

  logic grp01;
  assign grp01 = (op_byte[7:6] == 2'b01);

  always_comb begin
    cmd = '0;
    if (op_valid) begin
      if (!op_ext) begin
        cmd.dis  = (op_byte == OPC_DI);
        cmd.ena  = (op_byte == OPC_EI);
        cmd.pfx  = (op_byte == OPC_IXP) || (op_byte == OPC_IYP);
        cmd.halt = (op_byte == OPC_HALT);
      end else begin
        cmd.retx   = grp01 && (op_byte[2:0] == 3'b101);
        cmd.im_set = grp01 && (op_byte[2:0] == 3'b110);
        unique case (op_byte[4:3])
          2'b10:   cmd.im_val = 2'd1;
          2'b11:   cmd.im_val = 2'd2;
          default: cmd.im_val = 2'd0;
        endcase
        cmd.ld_pg = (op_byte == EXT_LDI);
        cmd.rd_ir = (op_byte == EXT_RDI) || (op_byte == EXT_RDR);
      end
    end
  end

endmodule

// File: rtl/icu_edge.sv
module icu_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic clr,
  output logic pend_eff
);

  logic prev_q;
  logic pend_q;
  logic fall;

  assign fall     = prev_q & ~line_n;
  assign pend_eff = pend_q | fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_n;
      pend_q <= pend_eff & ~clr;
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q); // R5

endmodule

// File: rtl/icu_pick.sv
module icu_pick
  import icu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TS_W    = 5,
  parameter int NMI_VEC = 'h0066,
  parameter int RST_VEC = 'h0038,
  parameter int TS_M0   = 13,
  parameter int TS_M1   = 13,
  parameter int TS_M2   = 19,
  parameter int TS_NMI  = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bnd,
  input  logic                  inh,
  input  logic                  busy,
  input  logic                  nmi_pend,
  input  logic                  int_n,
  input  logic                  iff1,
  input  logic [1:0]            im,
  input  logic [DATA_W-1:0]     vpage,
  input  logic [DATA_W-1:0]     bus,
  output logic                  take_nmi,
  output logic                  take_int,
  output act_kind_e             kind,
  output logic [2*DATA_W-1:0]   addr,
  output logic [DATA_W-1:0]     data,
  output logic [TS_W-1:0]       cyc
);

  localparam int ADDR_W = 2 * DATA_W;

  logic elig;
  assign elig     = bnd & ~inh & ~busy;
  assign take_nmi = elig & nmi_pend;
  assign take_int = elig & ~nmi_pend & ~int_n & iff1;

  always_comb begin
    kind = ACT_NMI;
    addr = ADDR_W'(NMI_VEC);
    data = '0;
    cyc  = TS_W'(TS_NMI);
    if (!nmi_pend) begin
      data = bus;
      unique case (im)
        2'd0: begin
          kind = ACT_BUS;
          addr = '0;
          cyc  = TS_W'(TS_M0);
        end
        2'd1: begin
          kind = ACT_RST;
          addr = ADDR_W'(RST_VEC);
          cyc  = TS_W'(TS_M1);
        end
        default: begin
          kind = ACT_TBL;
          addr = {vpage, bus};
          cyc  = TS_W'(TS_M2);
        end
      endcase
    end
  end

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_int})); // R7

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import icu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TS_W    = 5,
  parameter int NMI_VEC = 'h0066,
  parameter int RST_VEC = 'h0038,
  parameter int TS_M0   = 13,
  parameter int TS_M1   = 13,
  parameter int TS_M2   = 19,
  parameter int TS_NMI  = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nmi_n,
  input  logic                int_n,
  input  logic [DATA_W-1:0]   int_bus,
  input  logic                op_valid,
  input  logic                op_ext,
  input  logic [7:0]          op_byte,
  input  logic [DATA_W-1:0]   acc_in,
  input  logic                bnd,
  output logic                act_valid,
  input  logic                act_ready,
  output logic [1:0]          act_kind,
  output logic [2*DATA_W-1:0] act_addr,
  output logic [DATA_W-1:0]   act_byte,
  output logic [TS_W-1:0]     act_cycles,
  output logic                act_halt_exit,
  output logic                halt_o,
  output logic                en_main,
  output logic                en_save,
  output logic [1:0]          mode_o,
  output logic [DATA_W-1:0]   vpage_o,
  output logic                pv_valid,
  output logic                pv_o
);

  localparam int ADDR_W = 2 * DATA_W;

  op_cmd_t cmd;

  logic              iff1_q, iff2_q, halt_q, inh_q;
  logic [1:0]        im_q;
  logic [DATA_W-1:0] pg_q;

  logic              iff1_n, iff2_n, halt_n, inh_eff;
  logic [1:0]        im_n;
  logic [DATA_W-1:0] pg_n;

  logic              nmi_pend, take_nmi, take_int, take;
  act_kind_e         pk_kind;
  logic [ADDR_W-1:0] pk_addr;
  logic [DATA_W-1:0] pk_data;
  logic [TS_W-1:0]   pk_cyc;

  logic              av_q, hx_q, pvv_q, pv_q;
  act_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [TS_W-1:0]   cyc_q;

  icu_decode u_dec (
    .op_valid (op_valid),
    .op_ext   (op_ext),
    .op_byte  (op_byte),
    .cmd      (cmd)
  );

  // state as it stands once the current opcode has taken effect
  always_comb begin
    iff1_n = iff1_q;
    iff2_n = iff2_q;
    im_n   = im_q;
    pg_n   = pg_q;
    halt_n = halt_q;
    if (cmd.dis) begin
      iff1_n = 1'b0;
      iff2_n = 1'b0;
    end
    if (cmd.ena) begin
      iff1_n = 1'b1;
      iff2_n = 1'b1;
    end
    if (cmd.retx)   iff1_n = iff2_q;
    if (cmd.im_set) im_n   = cmd.im_val;
    if (cmd.ld_pg)  pg_n   = acc_in;
    if (cmd.halt)   halt_n = 1'b1;
  end

  assign inh_eff = inh_q | cmd.dis | cmd.ena | cmd.pfx;

  icu_edge u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_n   (nmi_n),
    .clr      (take_nmi),
    .pend_eff (nmi_pend)
  );

  icu_pick #(
    .DATA_W  (DATA_W),
    .TS_W    (TS_W),
    .NMI_VEC (NMI_VEC),
    .RST_VEC (RST_VEC),
    .TS_M0   (TS_M0),
    .TS_M1   (TS_M1),
    .TS_M2   (TS_M2),
    .TS_NMI  (TS_NMI)
  ) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .bnd      (bnd),
    .inh      (inh_eff),
    .busy     (av_q),
    .nmi_pend (nmi_pend),
    .int_n    (int_n),
    .iff1     (iff1_n),
    .im       (im_n),
    .vpage    (pg_n),
    .bus      (int_bus),
    .take_nmi (take_nmi),
    .take_int (take_int),
    .kind     (pk_kind),
    .addr     (pk_addr),
    .data     (pk_data),
    .cyc      (pk_cyc)
  );

  assign take = take_nmi | take_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
      im_q   <= 2'd0;
      pg_q   <= '0;
      halt_q <= 1'b0;
      inh_q  <= 1'b0;
      av_q   <= 1'b0;
      hx_q   <= 1'b0;
      kind_q <= ACT_NMI;
      addr_q <= '0;
      data_q <= '0;
      cyc_q  <= '0;
      pvv_q  <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      iff1_q <= take ? 1'b0 : iff1_n;
      iff2_q <= take_int ? 1'b0 : iff2_n;
      im_q   <= im_n;
      pg_q   <= pg_n;
      halt_q <= take ? 1'b0 : halt_n;
      inh_q  <= bnd ? 1'b0 : inh_eff;
      if (take) begin
        av_q   <= 1'b1;
        hx_q   <= halt_n;
        kind_q <= pk_kind;
        addr_q <= pk_addr;
        data_q <= pk_data;
        cyc_q  <= pk_cyc;
      end else if (av_q && act_ready) begin
        av_q <= 1'b0;
      end
      pvv_q <= cmd.rd_ir;
      if (cmd.rd_ir) pv_q <= iff2_q;
    end
  end

  assign act_valid     = av_q;
  assign act_kind      = kind_q;
  assign act_addr      = addr_q;
  assign act_byte      = data_q;
  assign act_cycles    = cyc_q;
  assign act_halt_exit = hx_q;
  assign halt_o        = halt_q;
  assign en_main       = iff1_q;
  assign en_save       = iff2_q;
  assign mode_o        = im_q;
  assign vpage_o       = pg_q;
  assign pv_valid      = pvv_q;
  assign pv_o          = pv_q;

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (av_q && !act_ready) |=> (av_q && $stable(addr_q) && $stable(kind_q) && $stable(cyc_q))); // R12
  AST_ACC_AT_BND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(av_q) |-> ($past(bnd) && !$past(inh_eff))); // R13
  AST_NMI_KEEPS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(av_q) && kind_q == ACT_NMI) |-> (!iff1_q && iff2_q == $past(iff2_q))); // R5
  AST_INT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(av_q) && kind_q != ACT_NMI) |-> (!iff1_q && !iff2_q)); // R6
  AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_q) |-> ($rose(av_q) && hx_q)); // R10
  AST_PV_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    pvv_q |-> (pv_q == $past(iff2_q))); // R11

endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi_n = 1'b1, int_n = 1'b1;
  logic [7:0] int_bus = 8'h00, op_byte = 8'h00, acc_in = 8'h00;
  logic       op_valid = 1'b0, op_ext = 1'b0, bnd = 1'b0, act_ready = 1'b1;
  logic       act_valid, act_halt_exit, halt_o, en_main, en_save, pv_valid, pv_o;
  logic [1:0] act_kind, mode_o;
  logic [15:0] act_addr;
  logic [7:0] act_byte, vpage_o;
  logic [4:0] act_cycles;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic m_iff1, m_iff2, m_halt, m_inh, m_pend, m_prev, m_av, m_hx, m_pvv, m_pv;
  logic [1:0] m_im, m_kind;
  logic [7:0] m_pg, m_byte;
  logic [15:0] m_addr;
  logic [4:0] m_cyc;

  always #4 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_n(int_n), .int_bus(int_bus),
    .op_valid(op_valid), .op_ext(op_ext), .op_byte(op_byte), .acc_in(acc_in),
    .bnd(bnd), .act_valid(act_valid), .act_ready(act_ready), .act_kind(act_kind),
    .act_addr(act_addr), .act_byte(act_byte), .act_cycles(act_cycles),
    .act_halt_exit(act_halt_exit), .halt_o(halt_o), .en_main(en_main),
    .en_save(en_save), .mode_o(mode_o), .vpage_o(vpage_o),
    .pv_valid(pv_valid), .pv_o(pv_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_of(input logic [7:0] b);
    return (b[4:3] == 2'b10) ? 2'd1 : (b[4:3] == 2'b11) ? 2'd2 : 2'd0;
  endfunction

  task automatic model_init();
    m_iff1 = 0; m_iff2 = 0; m_halt = 0; m_inh = 0; m_pend = 0; m_prev = 1;
    m_av = 0; m_hx = 0; m_pvv = 0; m_pv = 0; m_im = 0; m_kind = 0;
    m_pg = 0; m_byte = 0; m_addr = 0; m_cyc = 0;
  endtask

  // one clock: model the edge from the driven inputs, then compare
  task automatic tick();
    logic fall, o1, o2, oh, inh_e, pend_e, elig, tn, ti, pvv;
    logic [1:0] oim;
    logic [7:0] opg;
    fall = m_prev & ~nmi_n;
    o1 = m_iff1; o2 = m_iff2; oim = m_im; opg = m_pg; oh = m_halt; inh_e = m_inh; pvv = 0;
    if (op_valid && !op_ext) begin
      if (op_byte == 8'hF3) begin o1 = 0; o2 = 0; inh_e = 1; end
      if (op_byte == 8'hFB) begin o1 = 1; o2 = 1; inh_e = 1; end
      if (op_byte == 8'hDD || op_byte == 8'hFD) inh_e = 1;
      if (op_byte == 8'h76) oh = 1;
    end else if (op_valid) begin
      if ((op_byte & 8'hC7) == 8'h45) o1 = m_iff2;
      if ((op_byte & 8'hC7) == 8'h46) oim = mode_of(op_byte);
      if (op_byte == 8'h47) opg = acc_in;
      if (op_byte == 8'h57 || op_byte == 8'h5F) pvv = 1;
    end
    pend_e = m_pend | fall;
    elig = bnd & ~inh_e & ~m_av;
    tn = elig & pend_e;
    ti = elig & ~pend_e & ~int_n & o1;
    if (pvv) m_pv = m_iff2;
    m_pvv = pvv;
    m_prev = nmi_n;
    m_pend = pend_e & ~tn;
    m_inh = bnd ? 1'b0 : inh_e;
    m_iff1 = (tn | ti) ? 1'b0 : o1;
    m_iff2 = ti ? 1'b0 : o2;
    m_im = oim; m_pg = opg;
    if (tn | ti) begin
      m_av = 1; m_hx = oh;
      if (tn) begin m_kind = 0; m_addr = 16'h0066; m_byte = 0; m_cyc = 11; end
      else begin
        m_byte = int_bus;
        case (oim)
          2'd0: begin m_kind = 2; m_addr = 16'h0000; m_cyc = 13; end
          2'd1: begin m_kind = 1; m_addr = 16'h0038; m_cyc = 13; end
          default: begin m_kind = 3; m_addr = {opg, int_bus}; m_cyc = 19; end
        endcase
      end
    end else if (m_av && act_ready) m_av = 0;
    m_halt = (tn | ti) ? 1'b0 : oh;
    @(posedge clk);
    @(negedge clk);
    chk("R2/R3 en_main", en_main, m_iff1);
    chk("R2/R6 en_save", en_save, m_iff2);
    chk("R4 mode", mode_o, m_im);
    chk("R4 vpage", vpage_o, m_pg);
    chk("R10 halt", halt_o, m_halt);
    chk("R12/R13 act_valid", act_valid, m_av);
    if (m_av) begin
      chk("R8 kind", act_kind, m_kind);
      chk("R8 addr", act_addr, m_addr);
      chk("R8 byte", act_byte, m_byte);
      chk("R8 cycles", act_cycles, m_cyc);
      chk("R10 halt_exit", act_halt_exit, m_hx);
    end
    chk("R11 pv_valid", pv_valid, m_pvv);
    if (m_pvv) chk("R11 pv", pv_o, m_pv);
    op_valid = 0; bnd = 0;
  endtask

  task automatic op(input logic ext, input logic [7:0] b, input logic with_bnd);
    op_valid = 1; op_ext = ext; op_byte = b; bnd = with_bnd;
    tick();
  endtask

  task automatic boundary();
    bnd = 1;
    tick();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_init();
    repeat (3) @(negedge clk);
    chk("R1 reset en_main", en_main, 0);
    chk("R1 reset act_valid", act_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 en_save", en_save, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 vpage", vpage_o, 0);
    chk("R1 halt", halt_o, 0);

    op(0, 8'hFB, 0);
    chk("R2 ei sets", {en_main, en_save}, 2'b11);
    int_n = 0;
    op(0, 8'hFB, 1);
    chk("R9 no accept after ei", act_valid, 0);
    boundary();
    chk("R8 mode0 kind", act_kind, 2);
    chk("R8 mode0 cycles", act_cycles, 13);
    chk("R6 both cleared", {en_main, en_save}, 2'b00);
    int_n = 1;

    op(1, 8'h5E, 0);
    chk("R4 mode 2", mode_o, 2);
    acc_in = 8'h12;
    op(1, 8'h47, 0);
    chk("R4 vpage load", vpage_o, 8'h12);
    op(0, 8'hFB, 0);
    int_n = 0; int_bus = 8'h34;
    boundary();
    chk("R9 held off one boundary", act_valid, 0);
    boundary();
    chk("R8 table addr", act_addr, 16'h1234);
    chk("R8 table cycles", act_cycles, 19);
    int_n = 1;

    op(0, 8'hFB, 1);
    int_n = 0;
    tick(); tick();
    chk("R13 no accept without boundary", act_valid, 0);
    int_n = 1;
    op(1, 8'h56, 0);
    chk("R4 mode 1", mode_o, 1);

    int_n = 0; nmi_n = 0;
    boundary();
    chk("R7 nmi wins", act_kind, 0);
    chk("R5 nmi addr", act_addr, 16'h0066);
    chk("R5 nmi cycles", act_cycles, 11);
    chk("R5 only en_main cleared", {en_main, en_save}, 2'b01);
    int_n = 1; nmi_n = 1;
    op(1, 8'h4D, 0);
    chk("R3 return copies", en_main, 1);

    act_ready = 0; int_n = 0;
    boundary();
    chk("R8 restart addr", act_addr, 16'h0038);
    nmi_n = 0;
    boundary(); boundary();
    chk("R12 held valid", act_valid, 1);
    chk("R12 held kind", act_kind, 1);
    act_ready = 1; int_n = 1;
    boundary();
    boundary();
    chk("R5 latched edge serviced", act_kind, 0);
    nmi_n = 1;

    op(0, 8'h76, 0);
    chk("R10 halt raised", halt_o, 1);
    op(0, 8'hFB, 1);
    int_n = 0;
    boundary();
    chk("R10 halt exit", {halt_o, act_halt_exit}, 2'b01);
    int_n = 1;

    op(0, 8'hFB, 0);
    op(1, 8'h57, 0);
    chk("R11 pv from save", {pv_valid, pv_o}, 2'b11);
    op(0, 8'hF3, 0);
    chk("R2 di clears", {en_main, en_save}, 2'b00);
    op(1, 8'h5F, 0);
    chk("R11 pv zero", {pv_valid, pv_o}, 2'b10);
    op(1, 8'h6E, 0);
    chk("R4 6E gives mode 0", mode_o, 0);
    op(1, 8'h76, 0);
    chk("R4 ext 76 gives mode 1", mode_o, 1);
    boundary();
    int_n = 0;
    boundary();
    chk("R6 masked ignored", act_valid, 0);
    int_n = 1;

    for (int k = 0; k < 4000; k++) begin
      logic [7:0] tbl [0:19];
      int pick;
      tbl = '{8'hF3, 8'hFB, 8'hDD, 8'hFD, 8'h76, 8'h00, 8'h45, 8'h4D, 8'h55, 8'h7D,
              8'h46, 8'h4E, 8'h56, 8'h5E, 8'h66, 8'h7E, 8'h47, 8'h57, 8'h5F, 8'h44};
      pick = $urandom % 20;
      op_valid = ($urandom % 3) == 0;
      op_ext = (pick >= 6);
      op_byte = tbl[pick];
      bnd = $urandom % 2;
      int_n = ($urandom % 4) != 0;
      if (($urandom % 16) == 0) nmi_n = ~nmi_n;
      act_ready = ($urandom % 4) != 0;
      int_bus = 8'($urandom);
      acc_in = 8'($urandom);
      tick();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule